// File: doc/BRIEF.md
# BCD Clock-Calendar and Event Counter

This block keeps time of day and a calendar in packed-BCD registers: hundredths of a second, seconds, minutes, hours, a date field sharing a byte with a two-bit year, and a month field sharing a byte with a weekday. The chain advances on a 100 Hz tick. That tick comes from one of two time bases. The first is a fast reference strobe, divided by 256 and then thinned to 100 of every 128 slow ticks. The second is a 50 Hz strobe, where each pulse yields two ticks on consecutive cycles.

The same three low registers can instead act as a six-digit BCD event counter. In that mode they step once for each input pulse, with no divider in the path. Software-side logic reads and loads the six registers through one address port. A halt input freezes counting so that a time can be loaded safely. A mask input hides the year and weekday fields on read. Hours run in 24-hour or 12-hour form, selected by the top bit of the hours register itself.

Top module: `bcd_timekeeper`

## Requirements
- R1: Address 1 holds hundredths (00..99), address 2 seconds (00..59), address 3 minutes (00..59), all packed BCD; each wraps to 00 and carries one step into the next unit.
- R2: With hours bit 7 clear (24-hour form), hours bits 5:0 count 00..23 in BCD, and 23 wrapping to 00 advances the date by one day.
- R3: With hours bit 7 set (12-hour form), bits 5:0 run 12, 01..11, 12; bit 6 is the PM flag and toggles on each 11-to-12 step; the day advances only when 11 PM steps to 12 AM.
- R4: Address 5 holds the year in bits 7:6 and the BCD date in bits 5:0; the date wraps to 01 after 31 in months 01,03,05,07,08,10,12, after 30 in 04,06,09,11, and in month 02 after 29 when year is 0 and after 28 otherwise.
- R5: Address 6 holds the weekday in bits 7:5 and the BCD month in bits 4:0; the weekday steps 0..6 on every day change, the month steps 01..12 on date wrap, and the year steps 0..3 on month wrap.
- R6: While the mask input is high, reads of address 5 return bits 7:6 as zero and reads of address 6 return bits 7:5 as zero; other bits are unchanged.
- R7: While halt is high, no register changes except by a write, whatever pulses arrive.
- R8: In event mode, addresses 1..3 form one six-digit BCD counter (address 1 least significant), stepping once per reference pulse, wrapping 999999 to 000000, and leaving hours, date and month untouched.
- R9: With the fast base selected, every 256 reference pulses form one slow tick and 100 of every 128 slow ticks advance hundredths; 2048 pulses from reset give hundredths 06.
- R10: With the 50 Hz base selected, each isolated reference pulse advances hundredths by two.
- R11: After reset, addresses 1..4 read 00 (24-hour form), addresses 5 and 6 read 01, and addresses 0 and 7 read 00.
- R12: A write to addresses 1..6 takes effect at the next clock edge and overrides any count at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | One-cycle strobe from the selected time base or event source |
| base_50hz | input | 1 | 1 selects the 50 Hz base, 0 the fast divided base |
| event_mode | input | 1 | 1 turns addresses 1..3 into a pulse counter |
| halt | input | 1 | Freezes all counting |
| mask_rd | input | 1 | Hides year and weekday fields on read |
| addr | input | ADDR_W | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |

## Verification
The bound checker watches on every cycle that hundredths wrap from 99 to 00 on a count, that a date of 31 returns to 01 on a day change, and that halt and event mode hold the frozen registers. It also checks that masked reads never expose year or weekday bits. Month-length selection per month and year, the 12-hour PM sequence, the divider ratio of the fast base and the doubling of the 50 Hz base depend on loaded states and long pulse trains. These only show in the bench's directed scenarios, which load a time just before each rollover and read the result back through the port.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;
   localparam int REG_W = 8;
   localparam int N_LOW = 3;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [1:0] yr);
      case (mon)
         5'h02:                      return (yr == 2'd0) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic         en,
   output logic [W-1:0] nxt,
   output logic         wrap
);
   import bcd_tk_pkg::*;
   logic [7:0] wide_inc;

   if (W < 2 || W > 8) begin : g_bad_w
      $error("bcd_step: W must lie in 2..8");
   end

   always_comb begin
      wide_inc = bcd_inc(8'(val));
      wrap     = en && (val == hi);
      if (!en)       nxt = val;
      else if (wrap) nxt = lo;
      else           nxt = wide_inc[W-1:0];
   end
endmodule

// File: rtl/tk_tick_gen.sv
module tk_tick_gen #(
   parameter int PRE_DIV  = 256,
   parameter int FRAC_NUM = 100,
   parameter int FRAC_DEN = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_pulse,
   input  logic base_50hz,
   input  logic run,
   output logic tick
);
   localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
   localparam int ACC_W = $clog2(FRAC_NUM + FRAC_DEN + 1);

   if (PRE_DIV < 2) begin : g_bad_div
      $error("tk_tick_gen: PRE_DIV must be at least 2");
   end
   if (FRAC_NUM < 1 || FRAC_NUM > FRAC_DEN) begin : g_bad_frac
      $error("tk_tick_gen: need 1 <= FRAC_NUM <= FRAC_DEN");
   end

   logic [PRE_W-1:0] pre_q;
   logic             pre_hit;
   logic             fast_tick;
   logic             pend_q;

   assign pre_hit = run && !base_50hz && ref_pulse && (pre_q == PRE_W'(PRE_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pre_q <= '0;
      else if (run && !base_50hz && ref_pulse)
         pre_q <= pre_hit ? '0 : pre_q + PRE_W'(1);
   end

   if (FRAC_NUM == FRAC_DEN) begin : g_no_frac
      assign fast_tick = pre_hit;
   end else begin : g_frac
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] acc_sum;
      logic             ovf;
      assign acc_sum   = acc_q + ACC_W'(FRAC_NUM);
      assign ovf       = acc_sum >= ACC_W'(FRAC_DEN);
      assign fast_tick = pre_hit && ovf;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc_q <= '0;
         else if (pre_hit) acc_q <= ovf ? acc_sum - ACC_W'(FRAC_DEN) : acc_sum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= run && base_50hz && ref_pulse;
   end

   assign tick = base_50hz ? (run && (ref_pulse || pend_q)) : fast_tick;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
   parameter int ADDR_W   = 4,
   parameter int PRE_DIV  = 256,
   parameter int FRAC_NUM = 100,
   parameter int FRAC_DEN = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse,
   input  logic              base_50hz,
   input  logic              event_mode,
   input  logic              halt,
   input  logic              mask_rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data
);
   import bcd_tk_pkg::*;

   localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_YD   = ADDR_W'(5);
   localparam logic [ADDR_W-1:0] A_WM   = ADDR_W'(6);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("bcd_timekeeper: ADDR_W must be at least 3");
   end

   logic [7:0] unit_q   [N_LOW];
   logic [7:0] unit_nxt [N_LOW];
   logic [N_LOW:0] carry;
   logic [7:0] hour_q, hour_nxt;
   logic [1:0] year_q, year_nxt;
   logic [5:0] date_q, date_nxt;
   logic [2:0] wday_q, wday_nxt;
   logic [4:0] mon_q, mon_nxt;
   logic       run, tick, cnt_en, hour_en, day_carry, date_wrap, mon_wrap;

   assign run = !halt && !event_mode;

   tk_tick_gen #(
      .PRE_DIV (PRE_DIV),
      .FRAC_NUM(FRAC_NUM),
      .FRAC_DEN(FRAC_DEN)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_pulse(ref_pulse),
      .base_50hz(base_50hz),
      .run      (run),
      .tick     (tick)
   );

   assign cnt_en   = event_mode ? (ref_pulse && !halt) : tick;
   assign carry[0] = cnt_en;

   for (genvar i = 0; i < N_LOW; i++) begin : g_low
      logic [7:0] unit_hi;
      assign unit_hi = (event_mode || i == 0) ? 8'h99 : 8'h59;
      bcd_step #(.W(8)) u_step (
         .val (unit_q[i]),
         .lo  (8'h00),
         .hi  (unit_hi),
         .en  (carry[i]),
         .nxt (unit_nxt[i]),
         .wrap(carry[i+1])
      );
   end

   assign hour_en = carry[N_LOW] && !event_mode;

   always_comb begin
      hour_nxt  = hour_q;
      day_carry = 1'b0;
      if (hour_en) begin
         if (!hour_q[7]) begin
            if (hour_q[5:0] == 6'h23) begin
               hour_nxt[5:0] = 6'h00;
               day_carry     = 1'b1;
            end else begin
               hour_nxt[5:0] = 6'(bcd_inc({2'b00, hour_q[5:0]}));
            end
         end else if (hour_q[5:0] == 6'h11) begin
            hour_nxt[5:0] = 6'h12;
            hour_nxt[6]   = !hour_q[6];
            day_carry     = hour_q[6];
         end else if (hour_q[5:0] == 6'h12) begin
            hour_nxt[5:0] = 6'h01;
         end else begin
            hour_nxt[5:0] = 6'(bcd_inc({2'b00, hour_q[5:0]}));
         end
      end
   end

   bcd_step #(.W(6)) u_date (
      .val (date_q),
      .lo  (6'h01),
      .hi  (month_last(mon_q, year_q)),
      .en  (day_carry),
      .nxt (date_nxt),
      .wrap(date_wrap)
   );

   bcd_step #(.W(5)) u_mon (
      .val (mon_q),
      .lo  (5'h01),
      .hi  (5'h12),
      .en  (date_wrap),
      .nxt (mon_nxt),
      .wrap(mon_wrap)
   );

   assign year_nxt = mon_wrap ? year_q + 2'd1 : year_q;
   assign wday_nxt = !day_carry ? wday_q : (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_LOW; i++) unit_q[i] <= 8'h00;
         hour_q <= 8'h00;
         year_q <= 2'd0;
         date_q <= 6'h01;
         wday_q <= 3'd0;
         mon_q  <= 5'h01;
      end else if (wr_en) begin
         for (int i = 0; i < N_LOW; i++)
            if (addr == ADDR_W'(i + 1)) unit_q[i] <= wr_data;
         if (addr == A_HOUR) hour_q <= wr_data;
         if (addr == A_YD) begin
            year_q <= wr_data[7:6];
            date_q <= wr_data[5:0];
         end
         if (addr == A_WM) begin
            wday_q <= wr_data[7:5];
            mon_q  <= wr_data[4:0];
         end
      end else begin
         for (int i = 0; i < N_LOW; i++) unit_q[i] <= unit_nxt[i];
         hour_q <= hour_nxt;
         year_q <= year_nxt;
         date_q <= date_nxt;
         wday_q <= wday_nxt;
         mon_q  <= mon_nxt;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < N_LOW; i++)
         if (addr == ADDR_W'(i + 1)) rd_data = unit_q[i];
      if (addr == A_HOUR) rd_data = hour_q;
      if (addr == A_YD)   rd_data = {mask_rd ? 2'b00 : year_q, date_q};
      if (addr == A_WM)   rd_data = {mask_rd ? 3'b000 : wday_q, mon_q};
   end
endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt,
   input logic              event_mode,
   input logic              mask_rd,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rd_data,
   input logic              cnt_en,
   input logic              day_carry,
   input logic [7:0]        hund,
   input logic [7:0]        hour,
   input logic [5:0]        date
);
   AST_HUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !wr_en && !event_mode && hund == 8'h99) |=> hund == 8'h00); // R1

   AST_DATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (day_carry && !wr_en && date == 6'h31) |=> date == 6'h01); // R4

   AST_MASK_YEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd && addr == ADDR_W'(5)) |-> rd_data[7:6] == 2'b00); // R6

   AST_MASK_WDAY: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_rd && addr == ADDR_W'(6)) |-> rd_data[7:5] == 3'b000); // R6

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(halt && !wr_en) |-> (hund == $past(hund) && hour == $past(hour) && date == $past(date))); // R7

   AST_EVENT_HOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(event_mode && !wr_en) |-> (hour == $past(hour) && date == $past(date))); // R8
endmodule

bind bcd_timekeeper bcd_timekeeper_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .halt      (halt),
   .event_mode(event_mode),
   .mask_rd   (mask_rd),
   .wr_en     (wr_en),
   .addr      (addr),
   .rd_data   (rd_data),
   .cnt_en    (cnt_en),
   .day_carry (day_carry),
   .hund      (unit_q[0]),
   .hour      (hour_q),
   .date      (date_q)
);

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_pulse = 1'b0;
   logic       base_50hz = 1'b0;
   logic       event_mode = 1'b0;
   logic       halt = 1'b0;
   logic       mask_rd = 1'b0;
   logic [3:0] addr = 4'd0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_timekeeper u_bcd_timekeeper (
      .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .base_50hz(base_50hz),
      .event_mode(event_mode), .halt(halt), .mask_rd(mask_rd), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1;
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s addr %0d: got %h expected %h", req, a, rd_data, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] h, input logic [7:0] yd, input logic [7:0] wm);
      @(negedge clk);
      halt = 1'b1;
      wr(4'd1, 8'h98); wr(4'd2, 8'h59); wr(4'd3, 8'h59);
      wr(4'd4, h); wr(4'd5, yd); wr(4'd6, wm);
      @(negedge clk);
      halt = 1'b0;
   endtask

   task automatic step50();
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      rd_chk(4'd1, 8'h00, "R11"); rd_chk(4'd2, 8'h00, "R11");
      rd_chk(4'd3, 8'h00, "R11"); rd_chk(4'd4, 8'h00, "R11");
      rd_chk(4'd5, 8'h01, "R11"); rd_chk(4'd6, 8'h01, "R11");
      rd_chk(4'd0, 8'h00, "R11"); rd_chk(4'd7, 8'h00, "R11");
   endtask

   task automatic t_fast_base();
      base_50hz = 1'b0;
      for (int i = 0; i < 2048; i++) begin
         @(negedge clk); ref_pulse = 1'b1;
      end
      @(negedge clk); ref_pulse = 1'b0;
      rd_chk(4'd1, 8'h06, "R9");
   endtask

   task automatic t_50hz();
      base_50hz = 1'b1;
      step50();
      rd_chk(4'd1, 8'h08, "R10");
      step50();
      rd_chk(4'd1, 8'h10, "R10");
   endtask

   task automatic t_carry();
      set_time(8'h23, 8'h45, 8'h43);
      step50();
      rd_chk(4'd1, 8'h00, "R1"); rd_chk(4'd2, 8'h00, "R1");
      rd_chk(4'd3, 8'h00, "R1"); rd_chk(4'd4, 8'h00, "R2");
      rd_chk(4'd5, 8'h46, "R2"); rd_chk(4'd6, 8'h63, "R5");
   endtask

   task automatic t_months();
      set_time(8'h23, 8'h71, 8'h01); step50();   // Jan 31, year 1
      rd_chk(4'd5, 8'h41, "R4"); rd_chk(4'd6, 8'h22, "R4");
      set_time(8'h23, 8'h30, 8'h04); step50();   // Apr 30, year 0
      rd_chk(4'd5, 8'h01, "R4"); rd_chk(4'd6, 8'h25, "R4");
      set_time(8'h23, 8'h68, 8'h02); step50();   // Feb 28, year 1
      rd_chk(4'd5, 8'h41, "R4"); rd_chk(4'd6, 8'h23, "R4");
      set_time(8'h23, 8'h28, 8'h02); step50();   // Feb 28, year 0
      rd_chk(4'd5, 8'h29, "R4"); rd_chk(4'd6, 8'h22, "R4");
      set_time(8'h23, 8'h29, 8'h02); step50();   // Feb 29, year 0
      rd_chk(4'd5, 8'h01, "R4"); rd_chk(4'd6, 8'h23, "R4");
   endtask

   task automatic t_year();
      set_time(8'h23, 8'hF1, 8'hD2); step50();   // Dec 31, year 3, weekday 6
      rd_chk(4'd5, 8'h01, "R5"); rd_chk(4'd6, 8'h01, "R5");
   endtask

   task automatic t_12h();
      set_time(8'h91, 8'h05, 8'h01); step50();   // 11 AM
      rd_chk(4'd4, 8'hD2, "R3"); rd_chk(4'd5, 8'h05, "R3");
      set_time(8'hD1, 8'h05, 8'h01); step50();   // 11 PM
      rd_chk(4'd4, 8'h92, "R3"); rd_chk(4'd5, 8'h06, "R3");
      set_time(8'h92, 8'h06, 8'h01); step50();   // 12 AM
      rd_chk(4'd4, 8'h81, "R3");
   endtask

   task automatic t_mask();
      halt = 1'b1;
      wr(4'd5, 8'h95); wr(4'd6, 8'hA7);
      mask_rd = 1'b1;
      rd_chk(4'd5, 8'h15, "R6"); rd_chk(4'd6, 8'h07, "R6");
      mask_rd = 1'b0;
      rd_chk(4'd5, 8'h95, "R6"); rd_chk(4'd6, 8'hA7, "R6");
      halt = 1'b0;
   endtask

   task automatic t_halt();
      halt = 1'b1;
      wr(4'd1, 8'h42);
      repeat (6) step50();
      rd_chk(4'd1, 8'h42, "R7");
      halt = 1'b0;
   endtask

   task automatic t_event();
      event_mode = 1'b1;
      wr(4'd1, 8'h99); wr(4'd2, 8'h99); wr(4'd3, 8'h99); wr(4'd4, 8'h07);
      @(negedge clk); ref_pulse = 1'b1;
      @(negedge clk); ref_pulse = 1'b0;
      rd_chk(4'd1, 8'h00, "R8"); rd_chk(4'd2, 8'h00, "R8");
      rd_chk(4'd3, 8'h00, "R8"); rd_chk(4'd4, 8'h07, "R8");
      wr(4'd1, 8'h09);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); ref_pulse = 1'b1;
      end
      @(negedge clk); ref_pulse = 1'b0;
      rd_chk(4'd1, 8'h12, "R8");
   endtask

   task automatic t_write_wins();
      @(negedge clk);
      addr = 4'd1; wr_data = 8'h40; wr_en = 1'b1; ref_pulse = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; ref_pulse = 1'b0;
      rd_chk(4'd1, 8'h40, "R12");
      event_mode = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fast_base();
      t_50hz();
      t_carry();
      t_months();
      t_year();
      t_12h();
      t_mask();
      t_halt();
      t_event();
      t_write_wins();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule